// File: doc/BRIEF.md
# Status-Change Interrupt Monitor

This block watches three conditions of a chip: supply undervoltage, over-temperature and oscillator-good. It keeps one status bit for each. Whenever a status bit changes, in either direction, the block sets a sticky flag for that condition. When the condition's enable bit is also set, the block requests an interrupt.

The supply and temperature inputs are digital sample codes. Each code is compared against two separate thresholds, one that asserts the status and one that deasserts it, so the status has hysteresis. These two comparisons run only while the chip is in full-performance mode. The oscillator-good status is a qualified digital signal. It is cleared whenever the chip is in stop mode, the oscillator is disabled or the PLL is not locked.

Software clears flags by writing ones. It sets the enables with a plain register write. The interrupt line is registered, so it cannot glitch.

Top module: `status_irq_monitor`

## Requirements
- R1: Undervoltage status (bit 0 of `status_o`) becomes 1 at a clock edge where it is 0 and `vsup_code_i < uv_set_thr_i`. It becomes 0 at an edge where it is 1 and `vsup_code_i > uv_clr_thr_i`. Otherwise it keeps its value.
- R2: Over-temperature status (bit 1 of `status_o`) becomes 1 at an edge where it is 0 and `temp_code_i > ot_set_thr_i`. It becomes 0 at an edge where it is 1 and `temp_code_i < ot_clr_thr_i`. Otherwise it keeps its value.
- R3: At the same edge where a status bit changes value, rising or falling, the flag bit at the same position in `flag_o` becomes 1.
- R4: `irq_o` is a register output. In every cycle it equals the OR over the three conditions of (flag AND enable), using the flags shown on `flag_o` in that same cycle.
- R5: Bits 0 and 1 of `status_o` are evaluated only at edges where `full_perf_i` is 1. At other edges they hold, and no flag event arises from them.
- R6: Oscillator status (bit 2 of `status_o`) takes the value of `osc_ok_i & osc_en_i & pll_lock_i & ~stop_i` at every edge. This happens in every mode, so stop mode, oscillator disable or PLL unlock forces it to 0.
- R7: Flags are sticky. At an edge with `clr_we_i` = 1, each flag whose bit in `clr_mask_i` is 1 is cleared. If a status change for that condition happens at the same edge, the flag stays 1.
- R8: After reset, status, flags, enables and `irq_o` are all 0. A condition that is already true at the first evaluation gives exactly one flag event.
- R9: At an edge with `en_we_i` = 1, the enable bits take `en_data_i`. The bit order for enables, flags and status is 0 = undervoltage, 1 = over-temperature, 2 = oscillator-good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_perf_i | input | 1 | Full-performance mode; enables the voltage and temperature evaluation |
| vsup_code_i | input | CODE_W | Supply sample code |
| uv_set_thr_i | input | CODE_W | Undervoltage assert threshold |
| uv_clr_thr_i | input | CODE_W | Undervoltage deassert threshold (the higher one) |
| temp_code_i | input | CODE_W | Temperature sample code |
| ot_set_thr_i | input | CODE_W | Over-temperature assert threshold |
| ot_clr_thr_i | input | CODE_W | Over-temperature deassert threshold (the lower one) |
| osc_ok_i | input | 1 | Oscillator qualified-good indication |
| osc_en_i | input | 1 | Oscillator enabled |
| pll_lock_i | input | 1 | PLL locked |
| stop_i | input | 1 | Full stop mode |
| clr_we_i | input | 1 | Flag clear strobe |
| clr_mask_i | input | 3 | Write-one-to-clear flag mask |
| en_we_i | input | 1 | Enable register write strobe |
| en_data_i | input | 3 | Enable register write data |
| status_o | output | 3 | Condition status bits |
| flag_o | output | 3 | Sticky change flags |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
Some behaviours are checked by assertions on every cycle:
- the hysteresis comparator trips on the assert threshold and releases on the deassert threshold;
- every status change sets its flag, and flags stay set unless cleared;
- bits 0 and 1 of the status do not move outside full-performance mode;
- the oscillator status is forced low by stop mode, oscillator disable or PLL unlock;
- `irq_o` is never high without an enabled flag.

Other behaviours only the bench's scenarios can show:
- a sample that lies between the two thresholds leaves the status unchanged;
- a clear write and a status change at the same edge leave the flag set;
- a condition that is true at the first evaluation raises exactly one flag event;
- `irq_o` follows the enable writes.

// File: rtl/stsmon_pkg.sv
package stsmon_pkg;
  localparam int NUM_COND = 3;
  localparam int UV_IDX   = 0;
  localparam int OT_IDX   = 1;
  localparam int OSC_IDX  = 2;
endpackage

// File: rtl/hyst_level_monitor.sv
module hyst_level_monitor #(
  parameter int CODE_W   = 10,
  parameter bit TRIP_LOW = 1'b1   // 1: trips when code falls below set threshold
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] set_thr_i,
  input  logic [CODE_W-1:0] clr_thr_i,
  output logic              status_o,
  output logic              status_next_o
);
  logic trip, release_c, status_q, status_d;

  generate
    if (TRIP_LOW) begin : g_low
      assign trip      = (code_i < set_thr_i);
      assign release_c = (code_i > clr_thr_i);
    end else begin : g_high
      assign trip      = (code_i > set_thr_i);
      assign release_c = (code_i < clr_thr_i);
    end
  endgenerate

  always_comb begin
    status_d = status_q;
    if (active_i) begin
      if (!status_q && trip)          status_d = 1'b1;
      else if (status_q && release_c) status_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= 1'b0;
    else        status_q <= status_d;
  end

  assign status_o      = status_q;
  assign status_next_o = status_d;

  // R1 / R2: a trip while active and clear must set the status
  assert_trip_sets_R1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active_i) && !$past(status_q) && $past(trip)) |-> status_q);
  // R1 / R2: without a release the set status stays set
  assert_hold_set_R1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_q) && !$past(release_c)) |-> status_q);
  // R5: no movement while inactive
  assert_hold_inactive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(active_i) |-> (status_q == $past(status_q)));
endmodule

// File: rtl/cond_event_flag.sv
module cond_event_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic change_i,
  input  logic clr_i,
  input  logic en_we_i,
  input  logic en_bit_i,
  output logic flag_o,
  output logic en_o,
  output logic req_next_o
);
  logic flag_q, flag_d, en_q, en_d;

  always_comb begin
    flag_d = (flag_q & ~clr_i) | change_i;   // new event wins over clear
    en_d   = en_we_i ? en_bit_i : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
    end
  end

  assign flag_o     = flag_q;
  assign en_o       = en_q;
  assign req_next_o = flag_d & en_d;

  // R7: sticky unless cleared
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_q) && !$past(clr_i)) |-> flag_q);
  // R7: event beats clear
  assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(change_i) && $past(clr_i)) |-> flag_q);
endmodule

// File: rtl/status_irq_monitor.sv
module status_irq_monitor
  import stsmon_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_perf_i,
  input  logic [CODE_W-1:0] vsup_code_i,
  input  logic [CODE_W-1:0] uv_set_thr_i,
  input  logic [CODE_W-1:0] uv_clr_thr_i,
  input  logic [CODE_W-1:0] temp_code_i,
  input  logic [CODE_W-1:0] ot_set_thr_i,
  input  logic [CODE_W-1:0] ot_clr_thr_i,
  input  logic              osc_ok_i,
  input  logic              osc_en_i,
  input  logic              pll_lock_i,
  input  logic              stop_i,
  input  logic              clr_we_i,
  input  logic [2:0]        clr_mask_i,
  input  logic              en_we_i,
  input  logic [2:0]        en_data_i,
  output logic [2:0]        status_o,
  output logic [2:0]        flag_o,
  output logic              irq_o
);
  logic [NUM_COND-1:0] st_q, st_d, change, en_q, req_next;
  logic osc_q, osc_d, irq_q, irq_d;

  hyst_level_monitor #(.CODE_W(CODE_W), .TRIP_LOW(1'b1)) i_uv_mon (
    .clk(clk), .rst_n(rst_n), .active_i(full_perf_i),
    .code_i(vsup_code_i), .set_thr_i(uv_set_thr_i), .clr_thr_i(uv_clr_thr_i),
    .status_o(st_q[UV_IDX]), .status_next_o(st_d[UV_IDX]));

  hyst_level_monitor #(.CODE_W(CODE_W), .TRIP_LOW(1'b0)) i_ot_mon (
    .clk(clk), .rst_n(rst_n), .active_i(full_perf_i),
    .code_i(temp_code_i), .set_thr_i(ot_set_thr_i), .clr_thr_i(ot_clr_thr_i),
    .status_o(st_q[OT_IDX]), .status_next_o(st_d[OT_IDX]));

  // oscillator qualification, evaluated in every mode
  always_comb osc_d = osc_ok_i & osc_en_i & pll_lock_i & ~stop_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) osc_q <= 1'b0;
    else        osc_q <= osc_d;
  end

  assign st_q[OSC_IDX] = osc_q;
  assign st_d[OSC_IDX] = osc_d;

  always_comb change = st_d ^ st_q;

  for (genvar c = 0; c < NUM_COND; c++) begin : g_cond
    cond_event_flag i_flag (
      .clk(clk), .rst_n(rst_n),
      .change_i(change[c]), .clr_i(clr_we_i & clr_mask_i[c]),
      .en_we_i(en_we_i), .en_bit_i(en_data_i[c]),
      .flag_o(flag_o[c]), .en_o(en_q[c]), .req_next_o(req_next[c]));

    // R3: a status transition leaves its flag set
    assert_change_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[c] != $past(st_q[c])) |-> flag_o[c]);
  end

  always_comb irq_d = |req_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign status_o = st_q;
  assign irq_o    = irq_q;

  // R4: request only with an enabled flag
  assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> |(flag_o & en_q));
  // R4: an enabled flag always requests
  assert_irq_present_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_o & en_q)) |-> irq_o);
  // R6: forcing conditions clear oscillator status
  assert_osc_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_i || !osc_en_i || !pll_lock_i) |-> !status_o[OSC_IDX]);
endmodule

// File: tb/test_status_irq_monitor.sv
`timescale 1ns/1ps
module test_status_irq_monitor;
  localparam int W = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fp = 1'b0, ok = 1'b0, oen = 1'b0, lock = 1'b0, stp = 1'b0;
  logic [W-1:0] vs = 10'd500, uvs = 10'd300, uvc = 10'd350;
  logic [W-1:0] tc = 10'd100, ots = 10'd700, otc = 10'd650;
  logic cwe = 1'b0, ewe = 1'b0;
  logic [2:0] cm = 3'b000, ed = 3'b000;
  logic [2:0] st_o, fl_o;
  logic irq;

  typedef struct packed { logic [2:0] st; logic [2:0] fl; logic irq; } exp_t;
  exp_t exp_q[$];
  string tag_q[$];
  logic [2:0] m_st = 3'b0, m_fl = 3'b0, m_en = 3'b0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  status_irq_monitor #(.CODE_W(W)) i_status_irq_monitor (
    .clk(clk), .rst_n(rst_n), .full_perf_i(fp),
    .vsup_code_i(vs), .uv_set_thr_i(uvs), .uv_clr_thr_i(uvc),
    .temp_code_i(tc), .ot_set_thr_i(ots), .ot_clr_thr_i(otc),
    .osc_ok_i(ok), .osc_en_i(oen), .pll_lock_i(lock), .stop_i(stp),
    .clr_we_i(cwe), .clr_mask_i(cm), .en_we_i(ewe), .en_data_i(ed),
    .status_o(st_o), .flag_o(fl_o), .irq_o(irq));

  // driver: model next state from requirements, push, advance one cycle
  task automatic step(input string tag);
    logic [2:0] ns, nf, ne;
    exp_t e;
    ns = m_st;
    if (fp) begin
      if (!m_st[0] && vs < uvs) ns[0] = 1'b1;
      else if (m_st[0] && vs > uvc) ns[0] = 1'b0;
      if (!m_st[1] && tc > ots) ns[1] = 1'b1;
      else if (m_st[1] && tc < otc) ns[1] = 1'b0;
    end
    ns[2] = ok & oen & lock & ~stp;
    nf = (m_fl & ~(cwe ? cm : 3'b000)) | (ns ^ m_st);
    ne = ewe ? ed : m_en;
    m_st = ns; m_fl = nf; m_en = ne;
    e.st = ns; e.fl = nf; e.irq = |(nf & ne);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    cwe = 1'b0; ewe = 1'b0;
  endtask

  // monitor: pop and compare after each edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (st_o !== e.st || fl_o !== e.fl || irq !== e.irq) begin
        errors++;
        $display("FAIL %s: status=%b flag=%b irq=%b expected status=%b flag=%b irq=%b",
                 t, st_o, fl_o, irq, e.st, e.fl, e.irq);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (st_o !== 3'b0 || fl_o !== 3'b0 || irq !== 1'b0) begin
      errors++;
      $display("FAIL R8 reset: status=%b flag=%b irq=%b expected 000 000 0", st_o, fl_o, irq);
    end
    // R8: conditions true at first evaluation -> one event each
    fp = 1; vs = 10'd200; ok = 1; oen = 1; lock = 1;
    step("R8 first evaluation uv+osc");
    step("R8 no second event");
    // R7: W1C clears
    cwe = 1; cm = 3'b111; step("R7 clear all flags");
    // R1: between thresholds holds
    vs = 10'd320; step("R1 between thresholds holds set");
    vs = 10'd350; step("R1 at deassert threshold holds");
    vs = 10'd351; step("R1 release above deassert threshold");
    vs = 10'd310; step("R1 between thresholds stays clear");
    vs = 10'd300; step("R1 at set threshold no trip");
    cwe = 1; cm = 3'b001; step("R7 clear uv flag");
    // R2
    tc = 10'd700; step("R2 at set threshold no trip");
    tc = 10'd701; step("R2 trip above set threshold");
    tc = 10'd660; step("R2 between thresholds holds");
    // R9 / R4: enable temperature
    ewe = 1; ed = 3'b010; step("R9 R4 enable ot, irq rises");
    cwe = 1; cm = 3'b010; step("R4 clear ot flag drops irq");
    // R7 collision: clear + change at same edge
    tc = 10'd600; cwe = 1; cm = 3'b010; step("R7 event wins over clear");
    cwe = 1; cm = 3'b010; step("R7 clear after collision");
    // R5: outside full performance status holds
    fp = 0; vs = 10'd100; tc = 10'd900; step("R5 hold outside fpm");
    step("R5 still holding");
    fp = 1; step("R5 evaluation resumes");
    cwe = 1; cm = 3'b111; step("R7 clear all");
    // R6: forcing conditions
    ewe = 1; ed = 3'b100; stp = 1; step("R6 stop forces osc low");
    stp = 0; step("R6 osc good again");
    lock = 0; step("R6 pll loss forces osc low");
    lock = 1; oen = 0; step("R6 osc disable keeps low");
    oen = 1; ok = 0; step("R6 osc not ok keeps low");
    cwe = 1; cm = 3'b100; step("R4 clear osc flag");
    ewe = 1; ed = 3'b000; step("R9 disable all");
    ok = 1; step("R4 flag without enable no irq");
    step("R4 idle");
    repeat (2) @(posedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule